// File: doc/BRIEF.md
# Character-Based CRT Timing Controller

This block produces the raster timing for a character-mapped CRT display. A free-running prescaler inside the block makes a character-step enable once every sixteen system clocks. On each step a horizontal character counter advances. Below it sit a raster-line counter and a vertical character-row counter. Together they drive horizontal and vertical sync, a display-enable window, a 14-bit linear memory address and a raster row address. It also drives a 16-bit fetch address that packs these fields into the layout a video memory fetcher expects.

Timing parameters live in a small register file. A write strobe on `sel_we_i` loads a 5-bit register index from the data bus. A second strobe on `dat_we_i` writes the data bus into the selected register. All limit compares use exact equality. If a limit is lowered below a counter's current value, the counter runs on to its natural width wrap before the new limit can match.

Top module: `crt_timing_ctrl`

## Requirements
- R1: The character step fires on every sixteenth clock after reset, that is, on the clock where the 4-bit prescaler reads 15. On a step that is not a line end, the memory address advances by one modulo 2^14 and the horizontal counter advances by one. Between steps no output other than fetch bit 0 changes.
- R2: A line ends on the step where the incremented horizontal count equals R0+1 (index 0, horizontal total). On that step the horizontal counter returns to 0, horizontal display turns on, and the memory address is loaded from the row-start latch.
- R3: Every line end advances the 5-bit raster counter. When the raster counter reaches R9+1 (index 9, last raster line), it returns to 0, the 7-bit row counter advances, and the row-start latch takes the value of the store latch. `row_addr_o` shows the raster counter.
- R4: When the row counter reaches R4+1 (index 4, vertical total), it returns to 0 and vertical display turns on. The store latch is loaded with the start address {R12[5:0], R13[7:0]}, where index 12 is the high part and index 13 the low part. This value is then the first row's start address.
- R5: Vertical display turns off when the incremented row count equals R6 (index 6). Horizontal display turns off when the horizontal count equals R1 (index 1). On that same step the memory address of that step is copied into the store latch.
- R6: `hsync_o` rises on the step where the horizontal count equals R2 (index 2). It lasts R3[3:0] steps (index 3, low nibble), and a value of 0 gives 16 steps.
- R7: `vsync_o` rises at a row boundary where the new row count equals R7 (index 7). It lasts R3[7:4] lines, and a value of 0 gives 16 lines.
- R8: `disp_en_o` is high exactly when both the horizontal and the vertical display latches are set.
- R9: `fetch_addr_o` is built as follows. Bit 0 is the prescaler MSB. Bits 10:1 are memory address bits 9:0. Bits 13:11 are raster bits 2:0. Bits 15:14 are memory address bits 13:12.
- R10: The implemented register indices are 0, 1, 2, 3, 4, 6, 7, 9, 12 and 13. A data write to any other index has no effect on any output. If both strobes are high together, the data goes to the previously selected index.
- R11: While `rst_ni` is low, all counters, latches, registers and the prescaler are cleared, so every output reads 0.
- R12: Limits compare by exact equality. After R0 is lowered below the current horizontal count, the counter runs on through 255 and wraps to 0. The line then ends only when the count next reaches the new R0+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_we_i | input | 1 | Load register index from wr_data_i[4:0] |
| dat_we_i | input | 1 | Write wr_data_i into the selected register |
| wr_data_i | input | 8 | Write data bus |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| disp_en_o | output | 1 | Display-enable window |
| mem_addr_o | output | 14 | Linear character memory address |
| row_addr_o | output | 5 | Raster line within the character row |
| fetch_addr_o | output | 16 | Composed video fetch address |

## Verification
The assertions assume that `clk_i` runs continuously and that the register inputs may change on any clock. They make no assumption that the limits stay consistent with one another: the sync-start and line-restart properties hold whatever values R0 to R9 take, even while those registers change in mid-frame. The stimulus draws register values from $urandom with a fixed seed, within ranges that keep a whole frame short enough to wrap several times in a run. It mixes in directed cases: zero sync widths, a lowered horizontal total, and writes to unimplemented indices.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;
  localparam int unsigned HCW  = 8;   // horizontal counter width
  localparam int unsigned RCW  = 5;   // raster counter width
  localparam int unsigned VCW  = 7;   // row counter width
  localparam int unsigned MAW  = 14;  // memory address width
  localparam int unsigned SWW  = 4;   // sync width counter width
  localparam int unsigned SELW = 5;   // register index width
  localparam int unsigned DW   = 8;   // data bus width

  typedef enum logic [SELW-1:0] {
    IDX_HTOT  = 5'd0,
    IDX_HDSP  = 5'd1,
    IDX_HSPOS = 5'd2,
    IDX_SWID  = 5'd3,
    IDX_VTOT  = 5'd4,
    IDX_VDSP  = 5'd6,
    IDX_VSPOS = 5'd7,
    IDX_RLAST = 5'd9,
    IDX_STH   = 5'd12,
    IDX_STL   = 5'd13
  } reg_idx_e;

  typedef struct packed {
    logic [HCW-1:0] htot;
    logic [HCW-1:0] hdsp;
    logic [HCW-1:0] hspos;
    logic [SWW-1:0] hsw;
    logic [SWW-1:0] vsw;
    logic [VCW-1:0] vtot;
    logic [VCW-1:0] vdsp;
    logic [VCW-1:0] vspos;
    logic [RCW-1:0] rlast;
    logic [MAW-1:0] start;
  } crt_cfg_t;
endpackage

// File: rtl/crt_regfile.sv
`timescale 1ns/1ps
module crt_regfile
  import crt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_we_i,
  input  logic          dat_we_i,
  input  logic [DW-1:0] wr_data_i,
  output crt_cfg_t      cfg_o
);
  localparam int unsigned STHW = MAW - DW;

  logic [SELW-1:0] sel_q;
  crt_cfg_t        cfg_q;
  logic [STHW-1:0] sth_q;
  logic [DW-1:0]   stl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (sel_we_i) begin
      sel_q <= wr_data_i[SELW-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      sth_q <= '0;
      stl_q <= '0;
    end else if (dat_we_i) begin
      unique case (sel_q)
        IDX_HTOT:  cfg_q.htot  <= wr_data_i[HCW-1:0];
        IDX_HDSP:  cfg_q.hdsp  <= wr_data_i[HCW-1:0];
        IDX_HSPOS: cfg_q.hspos <= wr_data_i[HCW-1:0];
        IDX_SWID: begin
          cfg_q.hsw <= wr_data_i[SWW-1:0];
          cfg_q.vsw <= wr_data_i[2*SWW-1:SWW];
        end
        IDX_VTOT:  cfg_q.vtot  <= wr_data_i[VCW-1:0];
        IDX_VDSP:  cfg_q.vdsp  <= wr_data_i[VCW-1:0];
        IDX_VSPOS: cfg_q.vspos <= wr_data_i[VCW-1:0];
        IDX_RLAST: cfg_q.rlast <= wr_data_i[RCW-1:0];
        IDX_STH:   sth_q       <= wr_data_i[STHW-1:0];
        IDX_STL:   stl_q       <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_o       = cfg_q;
    cfg_o.start = {sth_q, stl_q};
  end

  // sel_q only changes on an index strobe
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(sel_q)); // R10
endmodule

// File: rtl/crt_hcount.sv
`timescale 1ns/1ps
module crt_hcount
  import crt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     step_i,
  input  crt_cfg_t cfg_i,
  output logic     line_end_o,
  output logic     hdsp_stop_o,
  output logic     hdsp_o,
  output logic     hsync_o
);
  logic [HCW-1:0] hcc_q, hcc_n;
  logic [HCW:0]   hcc_inc;
  logic [SWW-1:0] hsc_q, hsc_inc;
  logic           hsync_q, hdsp_q;

  assign hcc_inc     = {1'b0, hcc_q} + 1'b1;
  assign line_end_o  = (hcc_inc == ({1'b0, cfg_i.htot} + 1'b1));
  assign hcc_n       = line_end_o ? '0 : hcc_inc[HCW-1:0];
  assign hdsp_stop_o = (hcc_n == cfg_i.hdsp);
  assign hsc_inc     = hsc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcc_q   <= '0;
      hdsp_q  <= 1'b0;
      hsync_q <= 1'b0;
      hsc_q   <= '0;
    end else if (step_i) begin
      hcc_q <= hcc_n;
      if (hdsp_stop_o)     hdsp_q <= 1'b0;
      else if (line_end_o) hdsp_q <= 1'b1;
      if (hcc_n == cfg_i.hspos) begin
        hsync_q <= 1'b1;
        hsc_q   <= '0;
      end else if (hsync_q) begin
        hsc_q <= hsc_inc;
        // equality also catches the wrap to zero, so width 0 means full count
        if (hsc_inc == cfg_i.hsw) hsync_q <= 1'b0;
      end
    end
  end

  assign hdsp_o  = hdsp_q;
  assign hsync_o = hsync_q;

  AST_LINE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && line_end_o |=> hcc_q == '0); // R2
  AST_HSYNC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_q) |-> hsc_q == '0); // R6
  AST_HSYNC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(hsync_q) && $stable(hcc_q)); // R1
endmodule

// File: rtl/crt_vcount.sv
`timescale 1ns/1ps
module crt_vcount
  import crt_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           line_end_i,
  input  crt_cfg_t       cfg_i,
  output logic           row_wrap_o,
  output logic           frame_wrap_o,
  output logic           vdsp_o,
  output logic           vsync_o,
  output logic [RCW-1:0] ras_o
);
  logic [RCW-1:0] ras_q;
  logic [RCW:0]   ras_inc;
  logic [VCW-1:0] vcc_q, vcc_n;
  logic [VCW:0]   vcc_inc;
  logic [SWW-1:0] vsc_q, vsc_inc;
  logic           vsync_q, vdsp_q, vs_start;

  assign ras_inc      = {1'b0, ras_q} + 1'b1;
  assign row_wrap_o   = (ras_inc == ({1'b0, cfg_i.rlast} + 1'b1));
  assign vcc_inc      = {1'b0, vcc_q} + 1'b1;
  assign frame_wrap_o = row_wrap_o && (vcc_inc == ({1'b0, cfg_i.vtot} + 1'b1));
  assign vcc_n        = frame_wrap_o ? '0 : vcc_inc[VCW-1:0];
  assign vs_start     = row_wrap_o && (vcc_n == cfg_i.vspos);
  assign vsc_inc      = vsc_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q   <= '0;
      vcc_q   <= '0;
      vdsp_q  <= 1'b0;
      vsync_q <= 1'b0;
      vsc_q   <= '0;
    end else if (step_i && line_end_i) begin
      ras_q <= row_wrap_o ? '0 : ras_inc[RCW-1:0];
      if (row_wrap_o) begin
        vcc_q <= vcc_n;
        if (frame_wrap_o)                      vdsp_q <= 1'b1;
        else if (vcc_inc == {1'b0, cfg_i.vdsp}) vdsp_q <= 1'b0;
      end
      if (vs_start) begin
        vsync_q <= 1'b1;
        vsc_q   <= '0;
      end else if (vsync_q) begin
        vsc_q <= vsc_inc;
        if (vsc_inc == cfg_i.vsw) vsync_q <= 1'b0;
      end
    end
  end

  assign vdsp_o  = vdsp_q;
  assign vsync_o = vsync_q;
  assign ras_o   = ras_q;

  AST_VSYNC_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_q) |-> vsc_q == '0); // R7
  AST_FRAME_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && line_end_i && frame_wrap_o |=> vcc_q == '0 && vdsp_q && ras_q == '0); // R4
  AST_RAS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_i && line_end_i) |=> $stable(ras_q) && $stable(vcc_q)); // R3
endmodule

// File: rtl/crt_addr.sv
`timescale 1ns/1ps
module crt_addr
  import crt_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic           line_end_i,
  input  logic           row_wrap_i,
  input  logic           frame_wrap_i,
  input  logic           hdsp_stop_i,
  input  logic [MAW-1:0] start_i,
  output logic [MAW-1:0] ma_o
);
  logic [MAW-1:0] ma_q, row_q, store_q;
  logic [MAW-1:0] ma_n, row_n, store_t;

  always_comb begin
    store_t = frame_wrap_i ? start_i : store_q;
    row_n   = (line_end_i && row_wrap_i) ? store_t : row_q;
    ma_n    = line_end_i ? row_n : ma_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ma_q    <= '0;
      row_q   <= '0;
      store_q <= '0;
    end else if (step_i) begin
      ma_q    <= ma_n;
      row_q   <= row_n;
      store_q <= hdsp_stop_i ? ma_n : (line_end_i ? store_t : store_q);
    end
  end

  assign ma_o = ma_q;

  AST_MA_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !line_end_i |=> ma_q == $past(ma_q) + 1'b1); // R1
  AST_MA_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && line_end_i |=> ma_q == row_q); // R2
endmodule

// File: rtl/crt_timing_ctrl.sv
`timescale 1ns/1ps
module crt_timing_ctrl
  import crt_pkg::*;
#(
  parameter int unsigned DIVW = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_we_i,
  input  logic        dat_we_i,
  input  logic [7:0]  wr_data_i,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        disp_en_o,
  output logic [13:0] mem_addr_o,
  output logic [4:0]  row_addr_o,
  output logic [15:0] fetch_addr_o
);
  logic [DIVW-1:0] div_q;
  logic            step;
  crt_cfg_t        cfg;
  logic            line_end, hdsp_stop, hdsp, row_wrap, frame_wrap, vdsp;
  logic [RCW-1:0]  ras;
  logic [MAW-1:0]  ma;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end
  assign step = &div_q;

  crt_regfile u_regs (
    .clk_i, .rst_ni, .sel_we_i, .dat_we_i, .wr_data_i, .cfg_o(cfg)
  );

  crt_hcount u_h (
    .clk_i, .rst_ni, .step_i(step), .cfg_i(cfg),
    .line_end_o(line_end), .hdsp_stop_o(hdsp_stop), .hdsp_o(hdsp), .hsync_o
  );

  crt_vcount u_v (
    .clk_i, .rst_ni, .step_i(step), .line_end_i(line_end), .cfg_i(cfg),
    .row_wrap_o(row_wrap), .frame_wrap_o(frame_wrap), .vdsp_o(vdsp),
    .vsync_o, .ras_o(ras)
  );

  crt_addr u_a (
    .clk_i, .rst_ni, .step_i(step), .line_end_i(line_end),
    .row_wrap_i(row_wrap), .frame_wrap_i(frame_wrap),
    .hdsp_stop_i(hdsp_stop), .start_i(cfg.start), .ma_o(ma)
  );

  assign disp_en_o    = hdsp & vdsp;
  assign mem_addr_o   = ma;
  assign row_addr_o   = ras;
  assign fetch_addr_o = {ma[13:12], ras[2:0], ma[9:0], div_q[DIVW-1]};

  AST_DISP_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_o |-> hdsp && vdsp); // R8
  AST_STEP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step |=> $stable(mem_addr_o) && $stable(vsync_o) && $stable(disp_en_o)); // R1
endmodule

// File: tb/tb_crt_timing_ctrl.sv
`timescale 1ns/1ps
module tb_crt_timing_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0, dat_we = 1'b0;
  logic [7:0]  wdat = '0;
  logic        hsync, vsync, disp_en;
  logic [13:0] mem_addr;
  logic [4:0]  row_addr;
  logic [15:0] fetch_addr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crt_timing_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(sel_we), .dat_we_i(dat_we),
    .wr_data_i(wdat), .hsync_o(hsync), .vsync_o(vsync), .disp_en_o(disp_en),
    .mem_addr_o(mem_addr), .row_addr_o(row_addr), .fetch_addr_o(fetch_addr)
  );

  // reference model state
  int m_r[32];
  int m_sel, m_div;
  int m_hcc, m_ma, m_store, m_row, m_rlc, m_vcc, m_hsc, m_vsc;
  bit m_hd, m_vd, m_hs, m_vs;

  function automatic void m_reset();
    foreach (m_r[i]) m_r[i] = 0;
    m_sel = 0; m_div = 0; m_hcc = 0; m_ma = 0; m_store = 0; m_row = 0;
    m_rlc = 0; m_vcc = 0; m_hsc = 0; m_vsc = 0;
    m_hd = 0; m_vd = 0; m_hs = 0; m_vs = 0;
  endfunction

  function automatic void m_step();
    int  h1, ma_n, st, r1, v1;
    bit  le, vst;
    h1 = m_hcc + 1;
    le = (h1 == m_r[0] + 1);
    ma_n = (m_ma + 1) & 16'h3fff;
    st = m_store;
    vst = 0;
    if (le) begin
      r1 = m_rlc + 1;
      if (r1 == m_r[9] + 1) begin
        r1 = 0;
        v1 = m_vcc + 1;
        if (v1 == m_r[6]) m_vd = 0;
        if (v1 == m_r[4] + 1) begin
          v1 = 0; m_vd = 1;
          st = (m_r[12] << 8) | m_r[13];
        end
        m_vcc = v1 & 127;
        if (m_vcc == m_r[7]) begin m_vs = 1; m_vsc = 0; vst = 1; end
        m_row = st;
      end
      m_rlc = r1 & 31;
      if (m_vs && !vst) begin
        m_vsc = (m_vsc + 1) & 15;
        if (m_vsc == (m_r[3] >> 4)) m_vs = 0;
      end
      m_hd = 1; h1 = 0; ma_n = m_row;
    end
    m_hcc = h1 & 255;
    if (m_hcc == m_r[1]) begin m_hd = 0; st = ma_n; end
    m_store = st;
    m_ma = ma_n;
    if (m_hcc == m_r[2]) begin m_hs = 1; m_hsc = 0; end
    else if (m_hs) begin
      m_hsc = (m_hsc + 1) & 15;
      if (m_hsc == (m_r[3] & 15)) m_hs = 0;
    end
  endfunction

  function automatic int mask_for(int idx, int v);
    case (idx)
      0, 1, 2, 3, 13: return v & 255;
      4, 6, 7:        return v & 127;
      9:              return v & 31;
      12:             return v & 63;
      default:        return -1;
    endcase
  endfunction

  function automatic void m_tick(bit s, bit d, int v);
    if (m_div == 15) m_step();
    if (d && mask_for(m_sel, v) >= 0) m_r[m_sel] = mask_for(m_sel, v);
    if (s) m_sel = v & 31;
    m_div = (m_div + 1) & 15;
  endfunction

  function automatic int m_fetch();
    return (((m_ma >> 12) & 3) << 14) | ((m_rlc & 7) << 11) |
           ((m_ma & 10'h3ff) << 1) | ((m_div >> 3) & 1);
  endfunction

  task automatic chk(string tag, string nm, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R6", "hsync", int'(hsync), int'(m_hs));
    chk("R7", "vsync", int'(vsync), int'(m_vs));
    chk("R5,R8", "disp_en", int'(disp_en), int'(m_hd & m_vd));
    chk("R1,R2,R4,R5", "mem_addr", int'(mem_addr), m_ma);
    chk("R3", "row_addr", int'(row_addr), m_rlc);
    chk("R9", "fetch_addr", int'(fetch_addr), m_fetch());
  endtask

  task automatic cyc(bit s, bit d, int v);
    sel_we = s; dat_we = d; wdat = v[7:0];
    @(posedge clk);
    m_tick(s, d, v);
    @(negedge clk);
    sel_we = 1'b0; dat_we = 1'b0;
    cmp_all();
  endtask

  task automatic wr_reg(int idx, int v);
    cyc(1, 0, idx);
    cyc(0, 1, v);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0);
  endtask

  task automatic cfg_all(int r0, int r1, int r2, int r3, int r4, int r6,
                         int r7, int r9, int r12, int r13);
    wr_reg(0, r0); wr_reg(1, r1); wr_reg(2, r2); wr_reg(3, r3);
    wr_reg(4, r4); wr_reg(6, r6); wr_reg(7, r7); wr_reg(9, r9);
    wr_reg(12, r12); wr_reg(13, r13);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    m_reset();
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "hsync", int'(hsync), 0);
    chk("R11", "vsync", int'(vsync), 0);
    chk("R11", "disp_en", int'(disp_en), 0);
    chk("R11", "mem_addr", int'(mem_addr), 0);
    chk("R11", "row_addr", int'(row_addr), 0);
    chk("R11", "fetch_addr", int'(fetch_addr), 0);
    rst_n = 1'b1;

    // directed base timing
    cfg_all(9, 6, 7, 8'h23, 4, 3, 2, 2, 8'h30, 8'h10);
    run(16 * 320);

    // R6/R7: zero widths mean 16
    cfg_all(24, 12, 3, 8'h00, 20, 10, 1, 0, 8'h3f, 8'hf8);
    run(16 * 25 * 22 * 2);

    // R10: writes to unimplemented indices leave behaviour unchanged
    wr_reg(5, 8'hff); wr_reg(8, 8'h03); wr_reg(20, 8'h55); wr_reg(31, 8'h01);
    for (int i = 0; i < 600; i++) begin
      cyc(0, 0, 0);
      chk("R10", "mem_addr after ignored write", int'(mem_addr), m_ma);
    end

    // R12: lowering R0 below the running count
    cfg_all(40, 30, 35, 8'h44, 3, 2, 1, 1, 0, 0);
    while (m_hcc < 30) cyc(0, 0, 0);
    wr_reg(0, 10);
    run(16 * 260);
    chk("R12", "mem_addr after wrap", int'(mem_addr), m_ma);
    chk("R12", "hsync after wrap", int'(hsync), int'(m_hs));

    // constrained random configurations
    for (int c = 0; c < 6; c++) begin
      int r0, r4;
      r0 = 8 + ($urandom % 33);
      r4 = 2 + ($urandom % 9);
      cfg_all(r0, $urandom % (r0 + 1), $urandom % (r0 + 1), $urandom % 256,
              r4, $urandom % (r4 + 2), $urandom % (r4 + 1), $urandom % 8,
              $urandom % 64, $urandom % 256);
      for (int i = 0; i < 16 * 600; i++) begin
        if (($urandom % 997) == 0) wr_reg(5 + 3 * ($urandom % 2), $urandom % 256);
        else cyc(0, 0, 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule